// File: doc/BRIEF.md
# Load-Aware Thermal Shutdown Controller

This block decides which regulator channels to switch off when the die overheats, and when to switch them back on. A comparator flags that the die has gone past the shutdown temperature, a second comparator flags that it has cooled below the recovery temperature, and each channel reports whether it is carrying heavy load (above 50 mA). Only heavily loaded channels are forced off. A lightly loaded channel keeps running through the hot phase.

The band between the two temperature thresholds gives hysteresis. A channel that was forced off stays off until the cool flag arrives. The block then releases the channel and sends a one-cycle restart request, so that the regulator ramps up again through soft-start. The undervoltage lockout flag clears all thermal state, and so does turning every channel off. Turning a single channel off clears that channel's thermal flag. Sensing itself is outside the block: all of its inputs are digital flags sampled on the clock.

Top module: `thermal_guard`

## Requirements
- R1: After reset, no thermal_off bit and no softstart_req bit is set.
- R2: When over_temp is sampled high in the normal phase, every enabled channel with heavy_load high has its thermal_off bit set one cycle later. Channels with heavy_load low keep thermal_off at 0.
- R3: If both channels are heavy when the overheat is detected, both thermal_off bits are set.
- R4: During the hot phase, a channel whose heavy_load rises has its thermal_off bit set one cycle later, even after over_temp has fallen.
- R5: A thermal_off bit stays set through the hot phase when over_temp falls or the load drops, as long as cooled stays low.
- R6: In the hot phase, cooled sampled high together with over_temp low clears every thermal_off bit one cycle later and ends the hot phase.
- R7: At that release, softstart_req pulses for exactly one cycle on exactly the channels whose thermal_off bit was set. No other channel receives a pulse.
- R8: uvlo high clears all thermal_off bits one cycle later with no softstart_req pulse, and returns the block to the normal phase, so a later cooled flag produces no pulse.
- R9: chan_en low on a channel clears that channel's thermal_off bit with no pulse. chan_en low on all channels is shutdown and also returns the block to the normal phase.
- R10: In the normal phase, heavy_load produces no thermal_off bit, and cooled produces no softstart_req pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 2 | Per-channel enable (bit i = channel i) |
| uvlo | input | 1 | Input supply below lockout threshold |
| over_temp | input | 1 | Die above the shutdown temperature |
| cooled | input | 1 | Die below the recovery temperature |
| heavy_load | input | 2 | Channel load above 50 mA |
| thermal_off | output | 2 | Channel forced off by the thermal guard |
| softstart_req | output | 2 | One-cycle request to restart the channel through soft-start |

## Verification
A stuck or lost phase state shows up at the ports one cycle after the next cooled flag: either a pulse appears where none is due, or a held thermal_off bit does not clear. A corrupted channel flag shows up on thermal_off on the very next cycle. It then appears again as a wrong softstart_req pattern at release. The directed scenarios therefore sample thermal_off one cycle after each stimulus, and sample softstart_req both on the cycle of the release and on the cycle after it.

// File: rtl/thermal_guard_pkg.sv
// Package: shared types for the thermal guard.
// Assumes: die phase needs only two states.
package thermal_guard_pkg;
    typedef enum logic {
        PH_NORMAL = 1'b0,
        PH_HOT    = 1'b1
    } die_phase_t;
endpackage

// File: rtl/tg_die_phase.sv
// Module: tracks whether the die is in its hot phase.
// It drives a capture window, during which heavy channels are latched off,
// and a one-cycle release strobe at cool-down.
// Assumes: the flags are already synchronous to clk. clear_all has priority.
module tg_die_phase
    import thermal_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_all,
    input  logic over_temp,
    input  logic cooled,
    output logic capture,
    output logic release_now
);
    die_phase_t phase_q;

    // Decode the capture window and the release strobe from the current phase.
    always_comb begin
        capture     = !clear_all && ((phase_q == PH_HOT) || over_temp);
        release_now = !clear_all && (phase_q == PH_HOT) && cooled && !over_temp;
    end

    // Phase register: enter on overheat, leave on cool-down or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            phase_q <= PH_NORMAL;
        end else if (phase_q == PH_NORMAL && over_temp) begin
            phase_q <= PH_HOT;
        end else if (release_now) begin
            phase_q <= PH_NORMAL;
        end
    end

    // R10: in the normal phase, no release strobe is produced
    a_r10_no_release_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_NORMAL) |-> !release_now);
    // R6: release returns the die to the normal phase
    a_r6_release_ends_hot: assert property (@(posedge clk) disable iff (!rst_n)
        release_now |=> (phase_q == PH_NORMAL));
    // R8: a clear always lands in the normal phase
    a_r8_clear_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (phase_q == PH_NORMAL));
endmodule

// File: rtl/tg_chan_latch.sv
// Module: per-channel thermal-off flag and restart pulse.
// Assumes: release_now and capture come from tg_die_phase.
// Release has priority over capture.
module tg_chan_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_all,
    input  logic chan_on,
    input  logic heavy,
    input  logic capture,
    input  logic release_now,
    output logic off_q,
    output logic restart_q
);
    // Flag and pulse update: clear, release, capture, or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all || !chan_on) begin
            off_q     <= 1'b0;
            restart_q <= 1'b0;
        end else if (release_now) begin
            restart_q <= off_q;
            off_q     <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (capture && heavy) begin
                off_q <= 1'b1;
            end
        end
    end

    // R2: a heavy channel in the capture window is forced off
    a_r2_heavy_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && heavy && chan_on && !clear_all && !release_now) |=> off_q);
    // R5: a set flag holds until release or clear
    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (off_q && chan_on && !clear_all && !release_now) |=> off_q);
    // R7: the pulse is one cycle wide and needs a prior flag
    a_r7_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |=> !restart_q);
    a_r7_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> $past(off_q));
    // R8: a clear leaves no flag and no pulse
    a_r8_clear_silent: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (!off_q && !restart_q));
endmodule

// File: rtl/thermal_guard.sv
// Module: top of the load-aware thermal shutdown controller.
// Forces off heavily loaded channels during overheat, and requests
// soft-start on release.
// Assumes: all inputs are synchronous flags; N_CH channels share one die.
module thermal_guard #(
    parameter int N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] chan_en,
    input  logic            uvlo,
    input  logic            over_temp,
    input  logic            cooled,
    input  logic [N_CH-1:0] heavy_load,
    output logic [N_CH-1:0] thermal_off,
    output logic [N_CH-1:0] softstart_req
);
    logic clear_all;
    logic capture;
    logic release_now;

    // Global clear: undervoltage lockout or every channel shut down.
    always_comb clear_all = uvlo || (chan_en == '0);

    tg_die_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (clear_all),
        .over_temp  (over_temp),
        .cooled     (cooled),
        .capture    (capture),
        .release_now(release_now)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tg_chan_latch u_latch (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_all  (clear_all),
            .chan_on    (chan_en[i]),
            .heavy      (heavy_load[i]),
            .capture    (capture),
            .release_now(release_now),
            .off_q      (thermal_off[i]),
            .restart_q  (softstart_req[i])
        );
    end

    // R1: outputs are idle in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (thermal_off == '0 && softstart_req == '0));
    // R9: a channel that is switched off holds no thermal flag
    a_r9_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((thermal_off & ~$past(chan_en)) == '0));
endmodule

// File: tb/tb_thermal_guard.sv
module tb_thermal_guard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] chan_en;
    logic       uvlo;
    logic       over_temp;
    logic       cooled;
    logic [1:0] heavy_load;
    logic [1:0] thermal_off;
    logic [1:0] softstart_req;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    thermal_guard dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .uvlo(uvlo),
        .over_temp(over_temp), .cooled(cooled), .heavy_load(heavy_load),
        .thermal_off(thermal_off), .softstart_req(softstart_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic go_hot(input logic [1:0] hv);
        heavy_load = hv; over_temp = 1'b1; cooled = 1'b0;
        tick();
    endtask

    task automatic go_cool();
        over_temp = 1'b0; cooled = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 thermal_off", thermal_off, 2'b00);
        chk("R1 softstart_req", softstart_req, 2'b00);
    endtask

    task automatic t_normal();
        heavy_load = 2'b11; over_temp = 1'b0; cooled = 1'b0;
        tick();
        chk("R10 heavy without overheat", thermal_off, 2'b00);
        cooled = 1'b1;
        tick();
        chk("R10 cool in normal phase", softstart_req, 2'b00);
        heavy_load = 2'b00;
        tick();
    endtask

    task automatic t_single_then_late();
        go_hot(2'b01);
        chk("R2 only heavy ch0 off", thermal_off, 2'b01);
        heavy_load = 2'b11; over_temp = 1'b0;
        tick();
        chk("R4 late heavy ch1 off", thermal_off, 2'b11);
        heavy_load = 2'b00;
        tick();
        chk("R5 held in band", thermal_off, 2'b11);
        go_cool();
        chk("R6 cleared on cool", thermal_off, 2'b00);
        chk("R7 pulse both", softstart_req, 2'b11);
        tick();
        chk("R7 pulse one wide", softstart_req, 2'b00);
    endtask

    task automatic t_both();
        go_hot(2'b11);
        chk("R3 both heavy off", thermal_off, 2'b11);
        heavy_load = 2'b00;
        go_cool();
        chk("R6 both released", thermal_off, 2'b00);
    endtask

    task automatic t_light();
        go_hot(2'b10);
        chk("R2 light ch0 keeps running", thermal_off, 2'b10);
        heavy_load = 2'b00;
        go_cool();
        chk("R7 pulse only ch1", softstart_req, 2'b10);
        tick();
    endtask

    task automatic t_uvlo();
        go_hot(2'b11);
        uvlo = 1'b1;
        tick();
        chk("R8 uvlo clears", thermal_off, 2'b00);
        chk("R8 uvlo no pulse", softstart_req, 2'b00);
        uvlo = 1'b0; heavy_load = 2'b00;
        go_cool();
        chk("R8 no late pulse", softstart_req, 2'b00);
    endtask

    task automatic t_enable();
        go_hot(2'b11);
        chan_en = 2'b10;
        tick();
        chk("R9 ch0 off clears flag", thermal_off, 2'b10);
        chk("R9 no pulse on disable", softstart_req, 2'b00);
        heavy_load = 2'b00; chan_en = 2'b11;
        go_cool();
        chk("R9 release only ch1", softstart_req, 2'b10);
        go_hot(2'b11);
        chan_en = 2'b00;
        tick();
        chk("R9 shutdown clears", thermal_off, 2'b00);
        heavy_load = 2'b00; chan_en = 2'b11;
        go_cool();
        chk("R9 shutdown no pulse", softstart_req, 2'b00);
    endtask

    initial begin
        rst_n = 1'b0; chan_en = 2'b11; uvlo = 1'b0;
        over_temp = 1'b0; cooled = 1'b1; heavy_load = 2'b00;
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_normal();
        t_single_then_late();
        t_both();
        t_light();
        t_uvlo();
        t_enable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule